// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects 64 interrupt sources into two 32-bit banks and steers each one to one of two processor outputs. One is a normal interrupt and one is a fast interrupt. For each source, software picks level or edge detection, the active sense, and the output the source drives. Edge events are held in a latch until software acknowledges them. A per-source software bit can raise any source by hand. Each source has an enable bit, and each output has its own master enable.

Software reaches every setting and status word through a plain synchronous register port. A write takes effect at the clock edge where it is presented. A read returns its data one cycle after the request, flagged by a valid strobe. One read-only word gives the lowest-numbered source that is raising the normal output. It reads 64 when no such source exists.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset every source is level-sensitive, active-high, routed to the normal output and disabled, both master enables are off, both outputs are low, and the pending number reads 64.
- R2: Source n lives in bank n[5] at bit n[4:0]. In every banked register pair the word with the lower address serves bank 0 and the next word serves bank 1.
- R3: For a level source, its raw status bit equals the input XOR its polarity bit (polarity 1 means active-low). This holds in the same cycle as the input, with no clock in between.
- R4: For an edge source (type bit 1), the latch sets at the clock edge where the polarity-corrected input goes from 0 to 1. The latch holds after the input returns, and the latch is the source's raw status. Writing 1 to the acknowledge bit clears the latch and writing 0 leaves it alone. An edge seen in the same cycle as its acknowledge write leaves the latch set.
- R5: The enable word can be written whole. Writing ones to the enable-set word sets only those bits, and writing ones to the enable-clear word clears only those bits.
- R6: A set software bit makes the source's raw status 1 whatever its input.
- R7: Normal status is raw AND enable AND NOT route, and fast status is raw AND enable AND route (route bit 1 means the fast output).
- R8: `irq_out` is master bit 0 AND the OR of all normal status bits. `fiq_out` is master bit 1 AND the OR of all fast status bits.
- R9: The pending number is the lowest source index whose normal status is set, or 64 when none is set. Sources routed to the fast output never count.
- R10: The word address is 2*g+b, with b the bank. g is 0 route, 1 type, 2 polarity, 3 enable, 4 enable-set, 5 enable-clear, 6 acknowledge, 7 software, 8 raw, 9 normal status, 10 fast status. For g=11, b=0 is the master word and b=1 is the pending number. `bus_rvalid` rises the cycle after `bus_re` with the data in `bus_rdata`. Groups 4, 5 and 6 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| src_in | input | 64 | Interrupt source inputs, synchronous to clk |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The pair of functions that can collide is an edge arriving on a source and software's acknowledge write to that same source. Both act on the edge latch at one clock edge. The bench drives the rising input and the acknowledge write at the same falling edge, so the design sees both at the next rising edge. It then reads the raw status and expects the latch still set. A second acknowledge, with the input held steady, must then clear it.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Register group, taken from the upper address bits.
  typedef enum logic [3:0] {
    G_ROUTE = 4'd0,
    G_TYPE  = 4'd1,
    G_POL   = 4'd2,
    G_EN    = 4'd3,
    G_ENSET = 4'd4,
    G_ENCLR = 4'd5,
    G_ACK   = 4'd6,
    G_SWI   = 4'd7,
    G_RAW   = 4'd8,
    G_IRQST = 4'd9,
    G_FIQST = 4'd10,
    G_MISC  = 4'd11,
    G_R12   = 4'd12,
    G_R13   = 4'd13,
    G_R14   = 4'd14,
    G_R15   = 4'd15
  } grp_e;

  localparam int unsigned GRP_W = 4;

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned BSEL_W    = 1,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [BANK_W-1:0]                  wdata_i,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   route_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   type_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   pol_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   en_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   swi_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   ack_o,
  output logic [1:0]                         master_o
);

  grp_e              grp;
  logic [BSEL_W-1:0] bank;

  logic [NUM_BANKS-1:0][BANK_W-1:0] route_q, route_d;
  logic [NUM_BANKS-1:0][BANK_W-1:0] type_q,  type_d;
  logic [NUM_BANKS-1:0][BANK_W-1:0] pol_q,   pol_d;
  logic [NUM_BANKS-1:0][BANK_W-1:0] en_q,    en_d;
  logic [NUM_BANKS-1:0][BANK_W-1:0] swi_q,   swi_d;
  logic [1:0]                       master_q, master_d;
  logic                             cfg_ce;

  assign grp    = grp_e'(addr_i[ADDR_W-1 -: GRP_W]);
  assign bank   = addr_i[BSEL_W-1:0];
  assign cfg_ce = we_i;

  // Next-state decode for all configuration words.
  always_comb begin
    route_d  = route_q;
    type_d   = type_q;
    pol_d    = pol_q;
    en_d     = en_q;
    swi_d    = swi_q;
    master_d = master_q;
    ack_o    = '0;
    if (we_i) begin
      unique case (grp)
        G_ROUTE: route_d[bank] = wdata_i;
        G_TYPE:  type_d[bank]  = wdata_i;
        G_POL:   pol_d[bank]   = wdata_i;
        G_EN:    en_d[bank]    = wdata_i;
        G_ENSET: en_d[bank]    = en_q[bank] | wdata_i;
        G_ENCLR: en_d[bank]    = en_q[bank] & ~wdata_i;
        G_ACK:   ack_o[bank]   = wdata_i;
        G_SWI:   swi_d[bank]   = wdata_i;
        G_MISC:  if (bank == '0) master_d = wdata_i[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q  <= '0;
      type_q   <= '0;
      pol_q    <= '0;
      en_q     <= '0;
      swi_q    <= '0;
      master_q <= '0;
    end else if (cfg_ce) begin
      route_q  <= route_d;
      type_q   <= type_d;
      pol_q    <= pol_d;
      en_q     <= en_d;
      swi_q    <= swi_d;
      master_q <= master_d;
    end
  end

  assign route_o  = route_q;
  assign type_o   = type_q;
  assign pol_o    = pol_q;
  assign en_o     = en_q;
  assign swi_o    = swi_q;
  assign master_o = master_q;

endmodule

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] src_i,
  input  logic [BANK_W-1:0] type_i,
  input  logic [BANK_W-1:0] pol_i,
  input  logic [BANK_W-1:0] route_i,
  input  logic [BANK_W-1:0] en_i,
  input  logic [BANK_W-1:0] swi_i,
  input  logic [BANK_W-1:0] ack_i,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] irq_st_o,
  output logic [BANK_W-1:0] fiq_st_o
);

  logic [BANK_W-1:0] prev_q, prev_d;
  logic [BANK_W-1:0] latch_q, latch_d;
  logic [BANK_W-1:0] act_now, act_prev, rise;
  logic              smp_ce;

  assign smp_ce = 1'b1;

  // Polarity is applied to both samples, so changing it never fakes an edge.
  always_comb begin
    act_now  = src_i ^ pol_i;
    act_prev = prev_q ^ pol_i;
    rise     = act_now & ~act_prev;
    prev_d   = src_i;
    // A fresh edge wins over an acknowledge in the same cycle.
    latch_d  = type_i & ((latch_q & ~ack_i) | rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else if (smp_ce) begin
      prev_q  <= prev_d;
      latch_q <= latch_d;
    end
  end

  always_comb begin
    raw_o    = (type_i & latch_q) | (~type_i & act_now) | swi_i;
    irq_st_o = raw_o & en_i & ~route_i;
    fiq_st_o = raw_o & en_i & route_i;
  end

endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
  parameter int unsigned N = 64,
  parameter int unsigned W = 7
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o
);

  // Scan from the top so the lowest set index is the one that sticks.
  always_comb begin
    idx_o = W'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned BSEL_W    = $clog2(NUM_BANKS),
  parameter int unsigned ADDR_W    = GRP_W + BSEL_W,
  parameter int unsigned NUM_SRC   = NUM_BANKS * BANK_W,
  parameter int unsigned PEND_W    = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BANK_W-1:0]  bus_wdata,
  output logic [BANK_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_out,
  output logic               fiq_out
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  // Assert at once, release two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NUM_BANKS-1:0][BANK_W-1:0] route, typ, pol, en, swi, ack;
  logic [NUM_BANKS-1:0][BANK_W-1:0] raw, irq_st, fiq_st;
  logic [1:0]                       master;
  logic [NUM_SRC-1:0]               irq_vec, fiq_vec;
  logic [PEND_W-1:0]                pend;

  intc_regfile #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BSEL_W(BSEL_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .we_i(bus_we), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .route_o(route), .type_o(typ), .pol_o(pol), .en_o(en),
    .swi_o(swi), .ack_o(ack), .master_o(master)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_src_bank #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_sync_n),
      .src_i(src_in[b*BANK_W +: BANK_W]),
      .type_i(typ[b]), .pol_i(pol[b]), .route_i(route[b]),
      .en_i(en[b]), .swi_i(swi[b]), .ack_i(ack[b]),
      .raw_o(raw[b]), .irq_st_o(irq_st[b]), .fiq_st_o(fiq_st[b])
    );
    assign irq_vec[b*BANK_W +: BANK_W] = irq_st[b];
    assign fiq_vec[b*BANK_W +: BANK_W] = fiq_st[b];
  end

  intc_lowest #(.N(NUM_SRC), .W(PEND_W)) u_pend (
    .vec_i(irq_vec), .idx_o(pend)
  );

  assign irq_out = master[0] & (|irq_vec);
  assign fiq_out = master[1] & (|fiq_vec);

  // Registered read port.
  grp_e              rd_grp;
  logic [BSEL_W-1:0] rd_bank;
  logic [BANK_W-1:0] rdata_d;
  logic              rd_ce;

  assign rd_grp  = grp_e'(bus_addr[ADDR_W-1 -: GRP_W]);
  assign rd_bank = bus_addr[BSEL_W-1:0];
  assign rd_ce   = bus_re;

  always_comb begin
    unique case (rd_grp)
      G_ROUTE: rdata_d = route[rd_bank];
      G_TYPE:  rdata_d = typ[rd_bank];
      G_POL:   rdata_d = pol[rd_bank];
      G_EN:    rdata_d = en[rd_bank];
      G_SWI:   rdata_d = swi[rd_bank];
      G_RAW:   rdata_d = raw[rd_bank];
      G_IRQST: rdata_d = irq_st[rd_bank];
      G_FIQST: rdata_d = fiq_st[rd_bank];
      G_MISC:  rdata_d = (rd_bank == '0) ? BANK_W'(master) : BANK_W'(pend);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_re;
      if (rd_ce) bus_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned BSEL_W    = 1,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned PEND_W    = 7
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_we,
  input logic                             bus_re,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic [BANK_W-1:0]                bus_wdata,
  input logic                             bus_rvalid,
  input logic [NUM_BANKS-1:0][BANK_W-1:0] en,
  input logic [1:0]                       master,
  input logic [NUM_SRC-1:0]               irq_vec,
  input logic [NUM_SRC-1:0]               fiq_vec,
  input logic [PEND_W-1:0]                pend,
  input logic                             irq_out,
  input logic                             fiq_out
);

  logic [3:0]        grp;
  logic [BSEL_W-1:0] bank;
  assign grp  = bus_addr[ADDR_W-1 -: 4];
  assign bank = bus_addr[BSEL_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
    a_r5_enset: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && grp == 4'd4 && bank == BSEL_W'(b))
        |=> en[b] == ($past(en[b]) | $past(bus_wdata)));
    a_r5_enclr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && grp == 4'd5 && bank == BSEL_W'(b))
        |=> en[b] == ($past(en[b]) & ~$past(bus_wdata)));
  end

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (master[0] && irq_vec != '0));
  a_r8_fiq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> (master[1] && fiq_vec != '0));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & fiq_vec) == '0);
  a_r9_pend_none: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec == '0) |-> pend == PEND_W'(NUM_SRC));
  a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);

endmodule

bind dual_bank_intc intc_checker #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BSEL_W(BSEL_W),
  .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .PEND_W(PEND_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .en(en), .master(master), .irq_vec(irq_vec), .fiq_vec(fiq_vec),
  .pend(pend), .irq_out(irq_out), .fiq_out(fiq_out)
);

// File: tb/dual_bank_intc_tb_top.sv
`timescale 1ns/1ps
module dual_bank_intc_tb_top;

  localparam logic [4:0] A_ROUTE0 = 5'd0,  A_TYPE0 = 5'd2,  A_POL0 = 5'd4;
  localparam logic [4:0] A_EN0    = 5'd6,  A_EN1   = 5'd7;
  localparam logic [4:0] A_ENSET0 = 5'd8,  A_ENSET1 = 5'd9, A_ENCLR0 = 5'd10;
  localparam logic [4:0] A_ACK0   = 5'd12, A_SWI1  = 5'd15;
  localparam logic [4:0] A_RAW0   = 5'd16, A_RAW1  = 5'd17;
  localparam logic [4:0] A_IRQST0 = 5'd18, A_FIQST0 = 5'd20;
  localparam logic [4:0] A_MASTER = 5'd22, A_PEND  = 5'd23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] src_in = '0;
  logic        irq_out, fiq_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dual_bank_intc dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .src_in(src_in),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  // Monitor: pops the scoreboard whenever read data comes back.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(irq_out, 1'b0, "R1 irq_out after reset");
    chk(fiq_out, 1'b0, "R1 fiq_out after reset");
    rd(A_PEND, 32'd64, "R1 pending number after reset");
    rd(A_EN0, 32'h0, "R1 enable after reset");
    rd(A_TYPE0, 32'h0, "R1 type after reset");

    // R3 level source, R7 status gating, R8 master, R9 pending
    src_in[3] = 1'b1;
    rd(A_RAW0, 32'h8, "R3 level raw active-high");
    rd(A_IRQST0, 32'h0, "R7 disabled source");
    wr(A_EN0, 32'h8);
    rd(A_IRQST0, 32'h8, "R7 enabled source");
    chk(irq_out, 1'b0, "R8 master off");
    wr(A_MASTER, 32'h1);
    chk(irq_out, 1'b1, "R8 master on");
    rd(A_PEND, 32'd3, "R9 pending 3");
    wr(A_POL0, 32'h8);
    rd(A_RAW0, 32'h0, "R3 active-low with high input");
    chk(irq_out, 1'b0, "R3 polarity flip drops irq");
    rd(A_PEND, 32'd64, "R9 none pending");
    wr(A_POL0, 32'h0);
    src_in[3] = 1'b0;
    @(negedge clk);
    chk(irq_out, 1'b0, "R3 input low");

    // R2 bank mapping
    src_in[40] = 1'b1;
    rd(A_RAW1, 32'h100, "R2 source 40 in bank 1 bit 8");
    wr(A_ENSET1, 32'h100);
    rd(A_EN1, 32'h100, "R2 enable-set bank 1");
    rd(A_PEND, 32'd40, "R9 pending 40");
    src_in[3] = 1'b1;
    rd(A_PEND, 32'd3, "R9 lowest wins");
    src_in[3] = 1'b0; src_in[40] = 1'b0;
    rd(A_PEND, 32'd64, "R9 cleared");

    // R5 enable aliases, R10 write-only reads zero
    wr(A_EN0, 32'hF0);
    wr(A_ENSET0, 32'h0F);
    rd(A_EN0, 32'hFF, "R5 set alias");
    wr(A_ENCLR0, 32'h3C);
    rd(A_EN0, 32'hC3, "R5 clear alias");
    rd(A_ENSET0, 32'h0, "R10 set alias reads zero");
    rd(A_ACK0, 32'h0, "R10 acknowledge reads zero");

    // R4 edge latch
    wr(A_TYPE0, 32'h20);
    wr(A_ENSET0, 32'h20);
    @(negedge clk); src_in[5] = 1'b1;
    @(negedge clk); src_in[5] = 1'b0;
    chk(irq_out, 1'b1, "R4 edge latched drives irq");
    rd(A_RAW0, 32'h20, "R4 latch holds");
    wr(A_ACK0, 32'h0);
    rd(A_RAW0, 32'h20, "R4 zero acknowledge no effect");
    wr(A_ACK0, 32'h20);
    rd(A_RAW0, 32'h0, "R4 acknowledge clears");
    chk(irq_out, 1'b0, "R4 irq drops after acknowledge");
    // collision: edge and acknowledge at the same clock
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_ACK0; bus_wdata = 32'h20; src_in[5] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(A_RAW0, 32'h20, "R4 edge wins over acknowledge");
    src_in[5] = 1'b0;
    wr(A_ACK0, 32'h20);
    rd(A_RAW0, 32'h0, "R4 second acknowledge clears");

    // R7 routing to fast output, R8 fast master
    wr(A_ROUTE0, 32'h20);
    @(negedge clk); src_in[5] = 1'b1;
    @(negedge clk); src_in[5] = 1'b0;
    chk(irq_out, 1'b0, "R7 routed away from irq");
    chk(fiq_out, 1'b0, "R8 fast master off");
    rd(A_FIQST0, 32'h20, "R7 fast status");
    rd(A_IRQST0, 32'h0, "R7 normal status empty");
    rd(A_PEND, 32'd64, "R9 fast source not counted");
    wr(A_MASTER, 32'h3);
    chk(fiq_out, 1'b1, "R8 fast master on");
    wr(A_MASTER, 32'h1);
    chk(fiq_out, 1'b0, "R8 fast master off again");
    wr(A_ACK0, 32'h20);

    // R6 software interrupt on source 63
    wr(A_SWI1, 32'h8000_0000);
    rd(A_RAW1, 32'h8000_0000, "R6 software bit raw");
    wr(A_ENSET1, 32'h8000_0000);
    rd(A_PEND, 32'd63, "R6 software pending 63");
    chk(irq_out, 1'b1, "R6 software drives irq");
    wr(A_SWI1, 32'h0);
    rd(A_PEND, 32'd64, "R6 software cleared");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule